// File: doc/BRIEF.md
# GPIO Bank with Half-Word Masked Writes

This block is one bank of general-purpose I/O of up to 32 pins, controlled through a small word-addressed register port. Software sets an output data value, a per-pin direction and a per-pin output-driver enable. The bank drives a pad value and a tri-state enable for every pin. Pin levels are read back through a separate input register, which is fed by a two-stage synchronizer.

Two masked-write registers change any subset of output bits in one bus write, with no read-modify-write. Each covers one half of the bank. The upper 16 bits of the written word choose which of the lower 16 data bits are held. The block also keeps a per-pin interrupt mask, which software can only set. Interrupt detection itself lies outside the block. The parameter `NPINS` sets how many pins the bank implements. Any bit above that reads as zero and ignores writes.

Top module: `gpio_bank_mw`

## Requirements
- R1: While reset is asserted and after it is released, the output data, direction, output-enable and interrupt-mask state are all zero, so `pad_out`, `pad_oe` and `irq_mask` are zero.
- R2: A write to word address 0 replaces every output data bit with the written value. Address 0 reads back the output data, and `pad_out` equals it from the clock edge of the write.
- R3: A write to address 1 treats bits [31:16] as a hold mask and bits [15:0] as data. For each i in 0..15, output bit i takes data bit i when mask bit 16+i is 0 and keeps its value when that bit is 1. Output bits 16 and above are unchanged.
- R4: A write to address 2 uses the same mask/data split but targets the upper half. Data bit i goes to output bit 16+i when mask bit 16+i is 0, and output bits 0..15 are unchanged.
- R5: Addresses 1, 2 and 6 are write-only and read as zero.
- R6: Address 3 is the direction register, where 1 means output and 0 means input. It reads back exactly what was last written.
- R7: Address 4 is the output-enable register and reads back as written. `pad_oe` bit n is the AND of direction bit n and output-enable bit n.
- R8: Address 5 is read-only and returns the pin inputs delayed by two clock edges. A write to it changes nothing.
- R9: Writing 1s to address 6 sets the matching interrupt-mask bits, and writing 0s leaves them as they are. The mask (1 = masked) reads at address 7 and drives `irq_mask`.
- R10: Register bits at or above `NPINS` read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Pin levels from the pads |
| pad_out | output | NPINS | Output value per pin |
| pad_oe | output | NPINS | Driver enable per pin |
| irq_mask | output | NPINS | Interrupt mask per pin, 1 = masked |

## Verification
The bench targets bit placement in the two masked registers. A design that inverts the hold sense would write the held bits, and one that forgets the +16 offset would put upper-half data into the low pins. It writes all ones and then looks above bit `NPINS`, where a missing truncation would show stray ones. It writes zeros and single bits to the disable register, which exposes a mask that can be cleared. It also moves pins while changing the address, so an input path with the wrong number of stages is caught by the cycle-exact reference model.

// File: rtl/gpio_bank_mw.sv
module gpio_bank_mw #(
  parameter int NPINS = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] irq_mask
);
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_MLO  = 3'd1;
  localparam logic [2:0] A_MHI  = 3'd2;
  localparam logic [2:0] A_DIR  = 3'd3;
  localparam logic [2:0] A_OEN  = 3'd4;
  localparam logic [2:0] A_PIN  = 3'd5;
  localparam logic [2:0] A_IDIS = 3'd6;
  localparam logic [2:0] A_MASK = 3'd7;

  logic [NPINS-1:0] data_q, dir_q, oen_q, mask_q, sync1_q, sync2_q;
  logic [31:0] data_w, lo_w, hi_w;
  logic [15:0] hold, din;

  assign data_w = 32'(data_q);
  assign hold   = bus_wdata[31:16];
  assign din    = bus_wdata[15:0];

  always_comb begin
    lo_w = data_w;
    hi_w = data_w;
    lo_w[15:0]  = (data_w[15:0]  & hold) | (din & ~hold);
    hi_w[31:16] = (data_w[31:16] & hold) | (din & ~hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      oen_q   <= '0;
      mask_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (bus_we) begin
        case (bus_addr)
          A_DATA:  data_q <= bus_wdata[NPINS-1:0];
          A_MLO:   data_q <= lo_w[NPINS-1:0];
          A_MHI:   data_q <= hi_w[NPINS-1:0];
          A_DIR:   dir_q  <= bus_wdata[NPINS-1:0];
          A_OEN:   oen_q  <= bus_wdata[NPINS-1:0];
          A_IDIS:  mask_q <= mask_q | bus_wdata[NPINS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_w;
      A_DIR:   bus_rdata = 32'(dir_q);
      A_OEN:   bus_rdata = 32'(oen_q);
      A_PIN:   bus_rdata = 32'(sync2_q);
      A_MASK:  bus_rdata = 32'(mask_q);
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out  = data_q;
  assign pad_oe   = dir_q & oen_q;
  assign irq_mask = mask_q;

  logic unused_upper;
  assign unused_upper = ^{lo_w, hi_w};
endmodule

module gpio_bank_mw_chk #(
  parameter int NPINS = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] irq_mask
);
  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0) |=> pad_out == $past(bus_wdata[NPINS-1:0]));

  a_r3_all_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 3'd1 || bus_addr == 3'd2) && bus_wdata[31:16] == 16'hFFFF)
      |=> $stable(pad_out));

  a_r7_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd3) |-> ((32'(pad_oe) & ~bus_rdata) == 32'd0));

  a_r9_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_mask) & ~irq_mask) == '0));

  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd6) |=> irq_mask == ($past(irq_mask) | $past(bus_wdata[NPINS-1:0])));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((bus_rdata >> NPINS) == 32'd0));

  logic unused_in;
  assign unused_in = ^pin_in;
endmodule

bind gpio_bank_mw gpio_bank_mw_chk #(.NPINS(NPINS)) chk_i (.*);

// File: tb/gpio_bank_mw_tb.sv
module gpio_bank_mw_tb_top;
  localparam int NP = 22;
  localparam logic [31:0] M = (32'd1 << NP) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pad_out, pad_oe, irq_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank_mw #(.NPINS(NP)) dut_i (.*);

  logic [31:0] m_out, m_dir, m_oen, m_msk;
  logic [31:0] hist[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_oen = 0; m_msk = 0; hist[0] = 0; hist[1] = 0;
    end else begin
      hist[1] = hist[0];
      hist[0] = 32'(pin_in);
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_out = bus_wdata & M;
          3'd1: for (int i = 0; i < 16; i++) if (!bus_wdata[16+i]) m_out[i] = bus_wdata[i];
          3'd2: for (int i = 0; i < 16; i++) if (!bus_wdata[16+i]) m_out[16+i] = bus_wdata[i];
          3'd3: m_dir = bus_wdata & M;
          3'd4: m_oen = bus_wdata & M;
          3'd6: m_msk = m_msk | (bus_wdata & M);
          default: ;
        endcase
        m_out = m_out & M;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_out;
      3'd3: return m_dir;
      3'd4: return m_oen;
      3'd5: return hist[1];
      3'd7: return m_msk;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", 32'(pad_out), 0);
        chk("R1", 32'(pad_oe), 0);
        chk("R1", 32'(irq_mask), 0);
      end else begin
        chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
        chk("R10", bus_rdata & ~M, 0);
        chk("R3", 32'(pad_out), m_out);
        chk("R7", 32'(pad_oe), m_dir & m_oen);
        chk("R9", 32'(irq_mask), m_msk);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    bus_addr = 3'd0;
    #1 chk("R1", bus_rdata, 0);

    wr(3'd0, 32'hFFFF_FFFF);
    bus_addr = 3'd0;
    #1 chk("R10", bus_rdata, M);
    wr(3'd1, 32'hFF00_1234);
    chk("R3", 32'(pad_out), 32'h003F_FF34);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0000_00AA);
    chk("R4", 32'(pad_out), 32'h002A_0000);
    wr(3'd2, 32'hFFFE_0001);
    chk("R4", 32'(pad_out), 32'h002B_0000);

    wr(3'd3, 32'h0000_00F0);
    wr(3'd4, 32'h0000_0FF0);
    chk("R7", 32'(pad_oe), 32'h0000_00F0);
    bus_addr = 3'd1;
    #1 chk("R5", bus_rdata, 0);

    pin_in = 22'h15_5555;
    bus_addr = 3'd5;
    @(posedge clk); #2 chk("R8", bus_rdata, 0);
    @(posedge clk); #2 chk("R8", bus_rdata, 32'h0015_5555);
    wr(3'd5, 32'hFFFF_FFFF);
    bus_addr = 3'd0;
    #1 chk("R8", bus_rdata, 32'h002B_0000);

    wr(3'd6, 32'h0);
    chk("R9", 32'(irq_mask), 0);
    wr(3'd6, 32'h5);
    wr(3'd6, 32'h2);
    chk("R9", 32'(irq_mask), 32'h7);
    wr(3'd6, 32'h0);
    bus_addr = 3'd7;
    #1 chk("R9", bus_rdata, 32'h7);
    wr(3'd6, 32'hFFFF_FFFF);
    bus_addr = 3'd7;
    #1 chk("R10", bus_rdata, M);

    for (int k = 0; k < 600; k++) begin
      if (k % 3 == 0) pin_in = NP'($urandom);
      if (k % 2 == 0) wr(3'($urandom), $urandom);
      else begin
        @(posedge clk); #2 bus_addr = 3'($urandom);
      end
    end
    repeat (2) @(posedge clk);
    #3 summary();
  end
endmodule